// File: doc/BRIEF.md
# Field Parity Detector and Capture Line Window

This block watches a video timing stream made of separate horizontal and vertical sync signals, both sampled on the pixel clock. It finds the rising (leading) edge of each sync. It then decides the parity of every field by checking whether the vertical edge lands inside a short detection window. That window is timed in clocks from the most recent horizontal edge, and its start and length are programmable.

The block also counts lines within the current field. It raises a capture-enable while that line count lies inside a programmable range. Interlaced even fields use one start/end pair. Interlaced odd fields and all progressive input share a second pair. A progressive-mode flag forces every field to odd, so the even-field pair has no effect in that mode. A capture engine downstream uses the field flag to pick its buffer and uses capture-enable to gate its line writes.

Top module: `bt601_field_window`

## Requirements
- R1: A leading edge of a sync is a clock on which the input is 1 and was 0 on the previous clock. An input held high produces only one edge.
- R2: The line count is 0 after reset. A vertical leading edge clears it, and this takes priority over a horizontal edge on the same clock. Each horizontal leading edge otherwise adds one. The new value is visible on the clock after the edge, and the count saturates at 4095.
- R3: The clock of a horizontal leading edge has offset 0, and each later clock adds one to the offset. The detection window covers offsets `win_start` through `win_start + win_len`, inclusive.
- R4: On a vertical leading edge in interlaced mode, `field_odd` becomes 1 if the edge falls inside the window and 0 otherwise. The new value appears on the next clock and holds until the next vertical leading edge.
- R5: With `win_start` and `win_len` both 0, a field is odd only when the vertical edge falls on the same clock as the horizontal edge. One clock later gives even.
- R6: When `progressive` is 1, every vertical leading edge sets `field_odd` to 1 wherever the edge falls.
- R7: In interlaced mode with `field_odd` 0, `cap_en` is 1 exactly when `even_first <= line_cnt <= even_last`.
- R8: In interlaced mode with `field_odd` 1, `cap_en` is 1 exactly when `prog_first <= line_cnt <= prog_last`.
- R9: When `progressive` is 1, `cap_en` follows `prog_first`/`prog_last`, and the values of `even_first`/`even_last` have no effect.
- R10: After reset, `field_odd` is 0 and `line_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, leading edge rising |
| vsync | input | 1 | Vertical sync, leading edge rising |
| win_start | input | 12 | Window start offset in clocks after the horizontal edge |
| win_len | input | 8 | Window extension in clocks beyond the start |
| even_first | input | 12 | First captured line of an interlaced even field |
| even_last | input | 12 | Last captured line of an interlaced even field |
| prog_first | input | 12 | First captured line for odd or progressive fields |
| prog_last | input | 12 | Last captured line for odd or progressive fields |
| progressive | input | 1 | Non-interlaced mode flag |
| field_odd | output | 1 | Parity of the current field |
| line_cnt | output | 12 | Line number within the current field |
| cap_en | output | 1 | Current line lies in the capture range |

## Verification
The hardest case to reach from the ports is a vertical edge that falls exactly on the first or last clock of the window. This must be checked for a wide window as well as a narrow one, because an off-by-one at either bound only shows there. A table of vectors places the vertical edge a chosen number of clocks after an isolated horizontal edge, at each bound and one clock outside it. Directed runs then build even, odd and progressive fields and walk the line count through the capture ranges one horizontal pulse at a time. A long run of pulses drives the count to its saturation point.

// File: rtl/bt601_field_window.sv
module bt601_field_window #(
  parameter int START_W = 12,
  parameter int DUR_W   = 8,
  parameter int LINE_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               vsync,
  input  logic [START_W-1:0] win_start,
  input  logic [DUR_W-1:0]   win_len,
  input  logic [LINE_W-1:0]  even_first,
  input  logic [LINE_W-1:0]  even_last,
  input  logic [LINE_W-1:0]  prog_first,
  input  logic [LINE_W-1:0]  prog_last,
  input  logic               progressive,
  output logic               field_odd,
  output logic [LINE_W-1:0]  line_cnt,
  output logic               cap_en
);
  localparam int OFF_W = (START_W > DUR_W ? START_W : DUR_W) + 2;

  logic              hs_q, vs_q;
  logic              hs_rise, vs_rise;
  logic [OFF_W-1:0]  off_q, off_now, win_lo, win_hi;
  logic              in_win;
  logic [LINE_W-1:0] line_q;
  logic              field_q;
  logic              use_even;
  logic [LINE_W-1:0] lo_line, hi_line;

  assign hs_rise = hsync & ~hs_q;
  assign vs_rise = vsync & ~vs_q;

  assign off_now = hs_rise ? '0 : ((&off_q) ? off_q : off_q + 1'b1);
  assign win_lo  = OFF_W'(win_start);
  assign win_hi  = win_lo + OFF_W'(win_len);
  assign in_win  = (off_now >= win_lo) && (off_now <= win_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      off_q   <= '1;
      line_q  <= '0;
      field_q <= 1'b0;
    end else begin
      hs_q  <= hsync;
      vs_q  <= vsync;
      off_q <= off_now;
      if (vs_rise)
        line_q <= '0;
      else if (hs_rise && !(&line_q))
        line_q <= line_q + 1'b1;
      if (vs_rise)
        field_q <= progressive | in_win;
    end
  end

  assign use_even  = !progressive && !field_q;
  assign lo_line   = use_even ? even_first : prog_first;
  assign hi_line   = use_even ? even_last  : prog_last;
  assign cap_en    = (line_q >= lo_line) && (line_q <= hi_line);
  assign field_odd = field_q;
  assign line_cnt  = line_q;

  p_vs_clears_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> line_q == '0);
  p_hs_advances_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise && !(&line_q)) |=> line_q == $past(line_q) + 1'b1);
  p_line_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise && !vs_rise) |=> $stable(line_q));
  p_field_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(field_q));
  p_prog_forces_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && progressive) |=> field_q);
endmodule

// File: tb/bt601_field_window_tb_top.sv
`timescale 1ns/1ps
module bt601_field_window_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b0, vsync = 1'b0, progressive = 1'b0;
  logic [11:0] win_start = '0, even_first = '0, even_last = '0, prog_first = '0, prog_last = '0;
  logic [7:0]  win_len = '0;
  logic        field_odd, cap_en;
  logic [11:0] line_cnt;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bt601_field_window dut_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .win_start(win_start), .win_len(win_len),
    .even_first(even_first), .even_last(even_last),
    .prog_first(prog_first), .prog_last(prog_last),
    .progressive(progressive), .field_odd(field_odd),
    .line_cnt(line_cnt), .cap_en(cap_en));

  // {start[12], len[8], vsync offset from hsync edge[16], progressive, expected odd}
  localparam logic [37:0] VEC [12] = '{
    {12'd0,   8'd0,   16'd0,   1'b0, 1'b1},
    {12'd0,   8'd0,   16'd1,   1'b0, 1'b0},
    {12'd5,   8'd3,   16'd4,   1'b0, 1'b0},
    {12'd5,   8'd3,   16'd5,   1'b0, 1'b1},
    {12'd5,   8'd3,   16'd8,   1'b0, 1'b1},
    {12'd5,   8'd3,   16'd9,   1'b0, 1'b0},
    {12'd100, 8'd0,   16'd100, 1'b0, 1'b1},
    {12'd100, 8'd0,   16'd101, 1'b0, 1'b0},
    {12'd10,  8'd255, 16'd265, 1'b0, 1'b1},
    {12'd10,  8'd255, 16'd266, 1'b0, 1'b0},
    {12'd5,   8'd3,   16'd20,  1'b1, 1'b1},
    {12'd0,   8'd0,   16'd3,   1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hs_pulse();
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
  endtask

  task automatic even_field();
    win_start = 12'd4000; win_len = 8'd0;
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic odd_field();
    win_start = 12'd0; win_len = 8'd0;
    @(negedge clk); hsync = 1'b1; vsync = 1'b1;
    @(negedge clk); hsync = 1'b0; vsync = 1'b0;
  endtask

  task automatic walk_range(input int lo, input int hi, input string req);
    for (int ln = 0; ln <= 11; ln++) begin
      check(cap_en == ((ln >= lo) && (ln <= hi)), req, cap_en, (ln >= lo) && (ln <= hi));
      hs_pulse();
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_cnt == 0, "R10", line_cnt, 0);
    check(field_odd == 1'b0, "R10", field_odd, 0);

    for (int v = 0; v < 12; v++) begin
      int off;
      string tag;
      win_start   = VEC[v][37:26];
      win_len     = VEC[v][25:18];
      off         = int'(VEC[v][17:2]);
      progressive = VEC[v][1];
      tag = progressive ? "R6" : ((win_start == 0 && win_len == 0) ? "R5" : "R3");
      repeat (2) @(negedge clk);
      hsync = 1'b1;
      if (off == 0) vsync = 1'b1;
      for (int i = 1; i <= off; i++) begin
        @(negedge clk); hsync = 1'b0;
        if (i == off) vsync = 1'b1;
      end
      @(negedge clk); hsync = 1'b0;
      check(field_odd == VEC[v][0], tag, field_odd, VEC[v][0]);
      check(line_cnt == 0, "R2", line_cnt, 0);
      vsync = 1'b0;
    end
    progressive = 1'b0;

    // R2/R4: count lines, field held across horizontal pulses
    odd_field();
    for (int k = 0; k < 7; k++) hs_pulse();
    @(negedge clk);
    check(line_cnt == 7, "R2", line_cnt, 7);
    check(field_odd == 1'b1, "R4", field_odd, 1);

    // R1: held hsync gives one edge only
    @(negedge clk); hsync = 1'b1;
    repeat (5) @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    check(line_cnt == 8, "R1", line_cnt, 8);

    even_first = 12'd3; even_last = 12'd5;
    prog_first = 12'd7; prog_last = 12'd9;

    even_field();
    check(field_odd == 1'b0, "R4", field_odd, 0);
    walk_range(3, 5, "R7");

    odd_field();
    check(field_odd == 1'b1, "R8", field_odd, 1);
    walk_range(7, 9, "R8");

    progressive = 1'b1;
    even_field();
    even_first = 12'd0; even_last = 12'd11;
    walk_range(7, 9, "R9");
    progressive = 1'b0;

    // R2: saturation at 4095
    even_field();
    for (int k = 0; k < 4100; k++) hs_pulse();
    @(negedge clk);
    check(line_cnt == 4095, "R2", line_cnt, 4095);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule